// File: doc/BRIEF.md
# Two-Channel Serial Audio Word Receiver

The receiver takes a two-channel serial audio stream and turns it into parallel 16-bit samples in the system clock domain. The stream has three wires: a bit clock, a word clock that marks the channel, and serial data. Each word is a 16-bit two's complement value sent most significant bit first. The sender changes data on the falling edge of the bit clock, and the receiver takes one bit on each rising edge. All three wires pass through the same two-flop synchronizer, so a data bit and the bit-clock edge that qualifies it reach the system domain in the same cycle.

No bit count decides when a word is complete. The shift register keeps taking bits, and a change of the word clock moves its contents into the holding register of the channel that has just ended. A word clock that is low marks the left channel and a word clock that is high marks the right channel. A rising word-clock edge therefore commits the left sample. A falling edge commits the right sample and raises a one-cycle frame-valid strobe, so a consumer reads both samples as one pair.

Top module: `sai_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first commit, left_o and right_o read zero and frame_valid_o reads low.
- R2: The 16 bits received while the word clock is low (wclk_i = 0), taken MSB first, appear on left_o after the next rising edge of the word clock.
- R3: The 16 bits received while the word clock is high (wclk_i = 1), taken MSB first, appear on right_o after the next falling edge of the word clock.
- R4: sdata_i is sampled only at rising edges of bclk_i. A change of sdata_i while bclk_i is low has no effect on the received word.
- R5: When more than 16 bits arrive in one half frame, the channel output holds the last 16 bits received before the word-clock edge.
- R6: A channel output changes only on a word-clock edge. After 16 bits of a half frame, and before the edge, the previous value stays on the output.
- R7: frame_valid_o is a pulse one system clock long. It occurs once for each falling word-clock edge, in the cycle in which right_o takes its new value, and never on a rising edge.
- R8: With inputs driven between system clock edges, frame_valid_o goes high on the third rising edge of clk_i after the word clock falls. It is still low after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk_i |
| wclk_i | input | 1 | Word clock: low for the left channel, high for the right channel |
| sdata_i | input | 1 | Serial data, MSB first, changed on bclk_i falling edges |
| left_o | output | 16 | Last committed left sample |
| right_o | output | 16 | Last committed right sample |
| frame_valid_o | output | 1 | One-cycle strobe after a right-channel commit |

## Verification
The assertions assume that each high phase and each low phase of the bit clock lasts at least two system clocks, so that every level survives the synchronizer. They also assume that serial data settles at least one system clock before the rising bit-clock edge, and that the word clock changes only while the bit clock is low, well clear of the last rising edge. The stimulus holds each bit-clock phase for four system clocks. It puts the wrong data bit on the line for the first half of each low phase and the correct bit for the second half. It changes the word clock together with a falling bit-clock edge, at least four system clocks after the previous rising edge. All drives happen on the falling system clock edge, so that the latency of the synchronizer is exact.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic bclk;
    logic wclk;
    logic sdata;
  } line_t;

  localparam int unsigned LINE_W = $bits(line_t);
endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sai_rx_edge.sv
module sai_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_s_i,
  input  logic wclk_s_i,
  output logic bit_rise_o,
  output logic left_commit_o,
  output logic right_commit_o
);
  logic bclk_q, wclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_s_i;
      wclk_q <= wclk_s_i;
    end
  end

  assign bit_rise_o     = bclk_s_i & ~bclk_q;
  // low half (left) ends on a rising word clock
  assign left_commit_o  =  wclk_s_i & ~wclk_q;
  assign right_commit_o = ~wclk_s_i &  wclk_q;

  // R7
  right_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_commit_o |-> $past(wclk_s_i));
endmodule

// File: rtl/sai_rx_shifter.sv
module sai_rx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_o <= '0;
    else if (shift_en_i) word_o <= {word_o[W-2:0], bit_i};
  end

  // R4
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (word_o[0] == $past(bit_i)));
  // R4
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_o));
endmodule

// File: rtl/sai_rx_commit.sv
module sai_rx_commit #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         left_commit_i,
  input  logic         right_commit_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         frame_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o        <= '0;
      right_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      if (left_commit_i)  left_o  <= word_i;
      if (right_commit_i) right_o <= word_i;
      frame_valid_o <= right_commit_i;
    end
  end

  // R7
  fv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  // R7
  fv_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(right_commit_i));
  // R3
  right_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_o != $past(right_o)) |-> frame_valid_o);
  // R6
  left_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_o != $past(left_o)) |-> $past(left_commit_i));
endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_rx_pkg::*;
#(
  parameter int unsigned WORD_W_P = sai_rx_pkg::WORD_W,
  parameter int unsigned STAGES_P = sai_rx_pkg::SYNC_STAGES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  output logic [WORD_W_P-1:0] left_o,
  output logic [WORD_W_P-1:0] right_o,
  output logic                frame_valid_o
);
  line_t               line_raw, line_s;
  logic                bit_rise, left_commit, right_commit;
  logic [WORD_W_P-1:0] shreg;

  assign line_raw = '{bclk: bclk_i, wclk: wclk_i, sdata: sdata_i};

  // data travels with the clocks so alignment is kept
  sai_rx_sync #(.W(LINE_W), .STAGES(STAGES_P)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_raw),
    .q_o   (line_s)
  );

  sai_rx_edge edge_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bclk_s_i      (line_s.bclk),
    .wclk_s_i      (line_s.wclk),
    .bit_rise_o    (bit_rise),
    .left_commit_o (left_commit),
    .right_commit_o(right_commit)
  );

  sai_rx_shifter #(.W(WORD_W_P)) shift_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(bit_rise),
    .bit_i     (line_s.sdata),
    .word_o    (shreg)
  );

  sai_rx_commit #(.W(WORD_W_P)) commit_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_i        (shreg),
    .left_commit_i (left_commit),
    .right_commit_i(right_commit),
    .left_o        (left_o),
    .right_o       (right_o),
    .frame_valid_o (frame_valid_o)
  );

  // R7
  fv_no_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> !line_s.wclk);
endmodule

// File: tb/sai_rx_tb_top.sv
module sai_rx_tb_top;
  localparam int HALF = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [15:0] left_o, right_o;
  logic        frame_valid_o;

  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  sai_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk), .wclk_i(wclk),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o),
    .frame_valid_o(frame_valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wrong level first in the low phase, correct level before the rise (R4)
  task automatic drive_bit(input logic b);
    bclk = 1'b0; sdata = ~b;
    repeat (2) @(negedge clk_i);
    sdata = b;
    repeat (HALF - 2) @(negedge clk_i);
    bclk = 1'b1;
    repeat (HALF) @(negedge clk_i);
  endtask

  task automatic send_half(input logic lvl, input logic [15:0] w, input int extra);
    wclk = lvl;
    for (int i = 0; i < extra; i++) drive_bit(i[0] ^ w[15]);
    for (int i = 15; i >= 0; i--) drive_bit(w[i]);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int extra, input string tag);
    exp_q.push_back({l, r});
    tag_q.push_back(tag);
    send_half(1'b0, l, extra);
    send_half(1'b1, r, extra);
  endtask

  // drop the word clock to commit right; R8 latency
  task automatic close_stream;
    wclk = 1'b0; bclk = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 strobe low after 2 edges", {31'd0, frame_valid_o}, 32'd0);
    @(negedge clk_i);
    check("R8 strobe high after 3 edges", {31'd0, frame_valid_o}, 32'd1);
    repeat (8) @(negedge clk_i);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (frame_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected strobe", 32'd1, 32'd0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check({t, " R2 left"}, {16'd0, left_o}, {16'd0, e[31:16]});
          check({t, " R3 right"}, {16'd0, right_o}, {16'd0, e[15:0]});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 left reset", {16'd0, left_o}, 32'd0);
    check("R1 right reset", {16'd0, right_o}, 32'd0);
    check("R1 strobe reset", {31'd0, frame_valid_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 left after release", {16'd0, left_o}, 32'd0);

    send_frame(16'h8000, 16'h7FFF, 0, "R4 extremes");
    send_frame(16'hFFFF, 16'h0000, 0, "R4 all ones/zeros");
    close_stream();

    send_frame(16'hA5C3, 16'h3C5A, 0, "R2 pattern");
    // R6: after 16 left bits, before the rising edge, old left remains
    exp_q.push_back({16'h0001, 16'h8001});
    tag_q.push_back("R6 frame");
    send_half(1'b0, 16'h0001, 0);
    check("R6 left held before edge", {16'd0, left_o}, {16'd0, 16'hA5C3});
    repeat (4) @(negedge clk_i);
    check("R6 left held, no edge", {16'd0, left_o}, {16'd0, 16'hA5C3});
    send_half(1'b1, 16'h8001, 0);
    close_stream();

    // R5 over-length half frames
    send_frame(16'h1234, 16'hFEDC, 4, "R5 extra4");
    send_frame(16'h0F0F, 16'hC001, 7, "R5 extra7");
    close_stream();

    send_frame(16'h5555, 16'hAAAA, 0, "R3 alternating");
    close_stream();

    check("R7 one strobe per frame", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule